// File: doc/BRIEF.md
# USB Low-Speed Packet Transmitter

This block serialises a short packet onto the D+/D- pair of a low-speed USB link. On a start request it captures a byte count and a payload, takes the bus by asserting the output enable with the lines at idle J, and sends the sync byte. It then sends each buffered byte least significant bit first, with NRZI line coding and bit stuffing. It closes with an end-of-packet sequence and releases the bus. A handshake mode sends only sync and one PID byte. This mode serves replies such as ACK or NAK.

Each line symbol lasts a fixed number of clock cycles, 12 by default. Busy and a one-cycle done pulse let the surrounding logic sequence replies. A pending device address offered at an input is adopted only when a data packet completes, never after a handshake. The caller supplies the packet content, the payload CRC and the reply timing.

Top module: `usb_ls_tx`

## Requirements
- R1: After reset oe_o, dp_o, dm_o, busy_o and done_o are 0, and dev_addr_o is 0.
- R2: A start_i sampled while idle raises busy_o at the next clock edge. The block then drives idle J (dp_o=0, dm_o=1) with oe_o=1 for one bit period before the first sync bit.
- R3: Every line symbol is held for exactly BIT_CYC (12) clock cycles. The lines change only at symbol boundaries.
- R4: The packet has len_i bytes, including the sync byte, where 2 <= len_i <= 12; values outside that range are clamped. The first byte is the sync byte 0x80. Payload byte k is taken from data_i[8k+7:8k]. Every byte goes out least significant bit first.
- R5: NRZI coding: a 0 bit toggles the lines between J (dp_o=0, dm_o=1) and K (dp_o=1, dm_o=0), and a 1 bit keeps them. The lines start in J.
- R6: After six consecutive 1 bits an extra 0 bit is inserted and the run count restarts. This also applies when the sixth 1 is the last bit of a byte: the extra bit goes out before the next byte, or before end of packet.
- R7: End of packet is SE0 (dp_o=dm_o=0) for two bit periods, then J for one bit period. oe_o then goes to 0, with both lines at 0.
- R8: done_o is high for exactly one cycle. That cycle is the first one with oe_o=0 and busy_o=0 after the packet.
- R9: With handshake_i=1 the packet is sync followed by pid_i only; len_i and data_i have no effect.
- R10: start_i is ignored while busy_o=1. All request inputs are captured at the accepted start, so later changes have no effect on the packet in flight.
- R11: When a data packet (handshake_i=0) completes, dev_addr_o takes pend_addr_i. After a handshake packet dev_addr_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to send a packet (taken only when idle) |
| handshake_i | input | 1 | 1: send sync plus pid_i only |
| pid_i | input | 8 | PID byte for handshake mode |
| len_i | input | 4 | Total byte count including sync (2..12) |
| data_i | input | 88 | Payload bytes, byte k at bits 8k+7:8k |
| pend_addr_i | input | 7 | Device address to adopt after a data packet |
| dp_o | output | 1 | D+ line value |
| dm_o | output | 1 | D- line value |
| oe_o | output | 1 | Line driver enable (0 = high impedance) |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | One-cycle pulse when the bus is released |
| dev_addr_o | output | 7 | Committed device address |

## Verification
A wrong run count in the stuffing logic shows up as a missing or extra toggle on the lines. Every symbol after it is then shifted, and the packet's end moves by a whole bit period, so the error is visible at the exact done cycle. A wrong byte or bit pointer corrupts the line pattern within the same byte. The bench compares every symbol in its middle against a sequence it builds arithmetically from the request. A miscounted timer or EOP length moves the release and done pulse off the expected cycle.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_PRE, ST_DATA, ST_SE0, ST_EOPJ} tx_state_e;
  localparam logic [7:0] SYNC_BYTE = 8'h80;
endpackage

// File: rtl/usbtx_bit_timer.sv
module usbtx_bit_timer #(
  parameter int BIT_CYC = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = $clog2(BIT_CYC);
  localparam logic [CW-1:0] LAST = CW'(BIT_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  // R3
  timer_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/usbtx_nrzi_stuff.sv
module usbtx_nrzi_stuff #(
  parameter int RUN_LEN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  input  logic bit_i,
  output logic line_k_o,
  output logic stuff_o,
  output logic take_o
);
  localparam int OW = $clog2(RUN_LEN + 1);

  logic [OW-1:0] ones_q;
  logic          line_q;

  assign stuff_o  = (ones_q == OW'(RUN_LEN));
  assign take_o   = step_i && !stuff_o;
  assign line_k_o = line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b0;
      ones_q <= '0;
    end else if (clr_i) begin
      line_q <= 1'b0;
      ones_q <= '0;
    end else if (step_i) begin
      if (stuff_o || !bit_i) begin
        line_q <= ~line_q;
        ones_q <= '0;
      end else begin
        ones_q <= ones_q + 1'b1;
      end
    end
  end

  // R6
  ones_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= OW'(RUN_LEN));
  // R6
  stuff_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && stuff_o && !clr_i) |=> (line_q != $past(line_q)));
endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
  import usbtx_pkg::*;
#(
  parameter int BIT_CYC   = 12,
  parameter int MAX_BYTES = 12,
  parameter int ADDR_W    = 7,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1),
  localparam int PAY_W    = (MAX_BYTES - 1) * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              handshake_i,
  input  logic [7:0]        pid_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic [PAY_W-1:0]  data_i,
  input  logic [ADDR_W-1:0] pend_addr_i,
  output logic              dp_o,
  output logic              dm_o,
  output logic              oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] dev_addr_o
);
  localparam logic [CNT_W-1:0] MAXB = CNT_W'(MAX_BYTES);
  localparam logic [CNT_W-1:0] MINB = CNT_W'(2);

  tx_state_e         state_q;
  logic [7:0]        buf_q [MAX_BYTES];
  logic [CNT_W-1:0]  nbytes_q, byte_idx_q;
  logic [2:0]        bit_idx_q;
  logic              last_q, hs_q, se0_cnt_q, done_q;
  logic [ADDR_W-1:0] addr_q;

  logic tick, step, take, stuff, line_k, start_acc, cur_bit;
  logic [CNT_W-1:0] len_clamped;

  assign start_acc   = start_i && (state_q == ST_IDLE);
  assign len_clamped = (len_i < MINB) ? MINB : ((len_i > MAXB) ? MAXB : len_i);
  assign cur_bit     = buf_q[byte_idx_q][bit_idx_q];
  assign step        = tick && ((state_q == ST_PRE) ||
                                ((state_q == ST_DATA) && (stuff || !last_q)));

  usbtx_bit_timer #(.BIT_CYC(BIT_CYC)) u_timer (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(state_q != ST_IDLE), .tick_o(tick)
  );

  usbtx_nrzi_stuff #(.RUN_LEN(6)) u_nrzi (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(state_q == ST_IDLE),
    .step_i(step), .bit_i(cur_bit),
    .line_k_o(line_k), .stuff_o(stuff), .take_o(take)
  );

  // request capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < MAX_BYTES; k++) buf_q[k] <= '0;
      nbytes_q <= MINB;
      hs_q     <= 1'b0;
    end else if (start_acc) begin
      buf_q[0] <= SYNC_BYTE;
      for (int k = 1; k < MAX_BYTES; k++)
        buf_q[k] <= (k == 1 && handshake_i) ? pid_i : data_i[(k-1)*8 +: 8];
      nbytes_q <= handshake_i ? MINB : len_clamped;
      hs_q     <= handshake_i;
    end
  end

  // sequencing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      byte_idx_q <= '0;
      bit_idx_q  <= '0;
      last_q     <= 1'b0;
      se0_cnt_q  <= 1'b0;
      done_q     <= 1'b0;
      addr_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        bit_idx_q <= bit_idx_q + 1'b1;
        if (bit_idx_q == 3'd7) begin
          if (byte_idx_q == nbytes_q - 1'b1) last_q <= 1'b1;
          else                               byte_idx_q <= byte_idx_q + 1'b1;
        end
      end
      unique case (state_q)
        ST_IDLE: if (start_acc) begin
          state_q    <= ST_PRE;
          byte_idx_q <= '0;
          bit_idx_q  <= '0;
          last_q     <= 1'b0;
        end
        ST_PRE:  if (tick) state_q <= ST_DATA;
        ST_DATA: if (tick && !step) begin
          state_q   <= ST_SE0;
          se0_cnt_q <= 1'b0;
        end
        ST_SE0:  if (tick) begin
          if (se0_cnt_q) state_q <= ST_EOPJ;
          se0_cnt_q <= 1'b1;
        end
        ST_EOPJ: if (tick) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          if (!hs_q) addr_q <= pend_addr_i;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    oe_o = 1'b1; dp_o = 1'b0; dm_o = 1'b1;
    unique case (state_q)
      ST_IDLE: begin oe_o = 1'b0; dm_o = 1'b0; end
      ST_DATA: begin dp_o = line_k; dm_o = ~line_k; end
      ST_SE0:  dm_o = 1'b0;
      default: ;
    endcase
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign dev_addr_o = addr_q;

  // R3
  line_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && $past(oe_o) && !$past(tick)) |-> $stable({dp_o, dm_o}));
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!oe_o && !busy_o));
  // R10
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(nbytes_q) && $stable(hs_q)));
  // R11
  addr_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dev_addr_o) |-> (done_o && !hs_q));
  // R5
  data_no_se0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> (dp_o != dm_o));
endmodule

// File: tb/tb_usb_ls_tx.sv
`timescale 1ns/1ps
module tb_usb_ls_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, handshake_i = 1'b0;
  logic [7:0]  pid_i = '0;
  logic [3:0]  len_i = 4'd2;
  logic [87:0] data_i = '0;
  logic [6:0]  pend_addr_i = '0;
  logic        dp_o, dm_o, oe_o, busy_o, done_o;
  logic [6:0]  dev_addr_o;

  int checks = 0, errors = 0;
  logic [1:0] exp_q [200];
  int n_exp;

  always #5 clk = ~clk;

  usb_ls_tx dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .handshake_i(handshake_i),
    .pid_i(pid_i), .len_i(len_i), .data_i(data_i), .pend_addr_i(pend_addr_i),
    .dp_o(dp_o), .dm_o(dm_o), .oe_o(oe_o), .busy_o(busy_o), .done_o(done_o),
    .dev_addr_o(dev_addr_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // symbol codes {dp,dm}: J=01, K=10, SE0=00 (R5, R7)
  task automatic build(input bit hs, input logic [7:0] pid, input int nb, input logic [87:0] pay);
    int ones = 0;
    bit lvl = 0;
    logic [7:0] b;
    n_exp = 0;
    exp_q[n_exp++] = 2'b01;                       // R2 leading J
    for (int k = 0; k < nb; k++) begin
      b = (k == 0) ? 8'h80 : (hs ? pid : pay[(k-1)*8 +: 8]);
      for (int i = 0; i < 8; i++) begin
        if (!b[i]) begin lvl = ~lvl; ones = 0; end
        else ones++;
        exp_q[n_exp++] = lvl ? 2'b10 : 2'b01;
        if (ones == 6) begin                      // R6 stuffed zero
          lvl = ~lvl; ones = 0;
          exp_q[n_exp++] = lvl ? 2'b10 : 2'b01;
        end
      end
    end
    exp_q[n_exp++] = 2'b00;
    exp_q[n_exp++] = 2'b00;
    exp_q[n_exp++] = 2'b01;
  endtask

  task automatic run(input bit hs, input logic [7:0] pid, input int len,
                     input logic [87:0] pay, input bit poke, input string tag);
    int bad = -1;
    logic [1:0] got = '0;
    build(hs, pid, hs ? 2 : (len < 2 ? 2 : (len > 12 ? 12 : len)), pay);
    @(negedge clk);
    handshake_i = hs; pid_i = pid; len_i = len[3:0]; data_i = pay; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R2 busy after start", 32'(busy_o), 1);
    for (int s = 0; s < n_exp; s++) begin
      for (int c = 0; c < (s == 0 ? 6 : 12); c++) begin
        @(negedge clk);
        if (poke && s == 3 && c == 0) begin        // R10 start while busy
          start_i = 1'b1; handshake_i = ~hs; data_i = ~pay; pid_i = ~pid; len_i = 4'd5;
        end
        if (poke && s == 3 && c == 1) start_i = 1'b0;
      end
      if (bad < 0 && (oe_o !== 1'b1 || {dp_o, dm_o} !== exp_q[s])) begin
        bad = s; got = {dp_o, dm_o};
      end
    end
    chk(bad < 0, $sformatf("%s symbol %0d", tag, bad), 32'(got), 32'(bad < 0 ? 2'b00 : exp_q[bad]));
    repeat (6) @(negedge clk);
    chk(done_o === 1'b1 && oe_o === 1'b0 && busy_o === 1'b0 && dp_o === 1'b0 && dm_o === 1'b0,
        $sformatf("R3 R7 R8 release %s", tag), {27'b0, done_o, oe_o, busy_o, dp_o, dm_o}, 32'h10);
    @(negedge clk);
    chk(done_o === 1'b0 && oe_o === 1'b0, "R8 done one cycle", {30'b0, done_o, oe_o}, 0);
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [87:0] p;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({oe_o, dp_o, dm_o, busy_o, done_o} === 5'b0 && dev_addr_o === 7'd0, "R1 reset",
        {20'b0, oe_o, dp_o, dm_o, busy_o, done_o, dev_addr_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({oe_o, busy_o} === 2'b0, "R1 idle after reset", {30'b0, oe_o, busy_o}, 0);

    // R4 R5 sweep over every byte count with computed payload
    for (int n = 2; n <= 12; n++) begin
      p = '0;
      for (int k = 0; k < 11; k++) p[k*8 +: 8] = 8'((k * 37 + n * 11) & 8'hff);
      run(1'b0, 8'h00, n, p, 1'b0, $sformatf("R4 R5 len %0d", n));
    end
    // R6 heavy stuffing, all ones
    run(1'b0, 8'h00, 12, {88{1'b1}}, 1'b0, "R6 all ones");
    run(1'b0, 8'h00, 12, 88'h0, 1'b0, "R5 all zeros");
    // R6 run completes on last bit of a byte, mid packet and at packet end
    run(1'b0, 8'h00, 3, {72'h0, 8'h00, 8'hFC}, 1'b0, "R6 stuff before next byte");
    run(1'b0, 8'h00, 2, {80'h0, 8'hFC}, 1'b0, "R6 stuff before EOP");
    run(1'b0, 8'h00, 4, {64'h0, 8'h7F, 8'hFF, 8'hFE}, 1'b0, "R6 cross-byte run");
    // R4 clamping
    run(1'b0, 8'h00, 15, {88{1'b1}} ^ 88'h0123456789ABCDEF012345, 1'b0, "R4 clamp high");
    run(1'b0, 8'h00, 0, 88'h5A, 1'b0, "R4 clamp low");
    // R9 handshake ignores len/data
    run(1'b1, 8'hD2, 9, {88{1'b1}}, 1'b0, "R9 ACK");
    run(1'b1, 8'h5A, 12, 88'h123456, 1'b0, "R9 NAK");
    run(1'b1, 8'h1E, 3, 88'h0, 1'b0, "R9 STALL");
    // R10 start mid-packet ignored
    run(1'b0, 8'h00, 6, 88'h00_1122_3344_5566, 1'b1, "R10 data");
    run(1'b1, 8'hD2, 2, 88'h0, 1'b1, "R10 handshake");
    // R11 address commit
    pend_addr_i = 7'h2A;
    run(1'b0, 8'h00, 3, 88'hC3A5, 1'b0, "R11 data a");
    chk(dev_addr_o === 7'h2A, "R11 commit after data", 32'(dev_addr_o), 32'h2A);
    pend_addr_i = 7'h15;
    run(1'b1, 8'hD2, 2, 88'h0, 1'b0, "R11 hs");
    chk(dev_addr_o === 7'h2A, "R11 held after handshake", 32'(dev_addr_o), 32'h2A);
    run(1'b0, 8'h00, 2, 88'h69, 1'b0, "R11 data b");
    chk(dev_addr_o === 7'h15, "R11 commit second", 32'(dev_addr_o), 32'h15);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule